// File: doc/BRIEF.md
# Variable-Length Instruction Fetch With Next-PC Prediction

This block is the first stage of a five-stage pipelined 64-bit processor whose instructions are 1, 2, 9 or 10 bytes long. Each cycle it picks the address to fetch, either the address it predicted last cycle or a correction sent back from a later stage. It then reads a ten-byte window from a private 2 KB byte-addressed instruction store at that address and breaks the window into its fields: opcode, function code, two register specifiers and a 64-bit little-endian constant. It also produces the fall-through address and a prediction of the next fetch address.

The fetch path is combinational from the selected address to every field output. The stage register that holds the prediction lives outside the block. A byte-wide load port fills the instruction store, and reset clears the store. Three flags come with every fetch: one for an opcode outside the supported set, one for a fetch address past the end of the store, and one for a halt instruction.

Top module: `fetch_unit`

## Requirements
- R1: While `rst_n` is low the whole instruction store reads as zero, and a `load_we` write presented during reset leaves the addressed byte unchanged (still 0x00).
- R2: `out_icode` is bits 7:4 and `out_ifun` is bits 3:0 of the byte at the fetch address. The opcodes are halt=0, nop=1, cmov=2, irmovq=3, rmmovq=4, mrmovq=5, OPq=6, jXX=7, call=8, ret=9, pushq=0xA and popq=0xB.
- R3: `out_valp` equals the fetch address plus the instruction length. The length is 1 for halt, nop, ret and illegal opcodes; 2 for cmov, OPq, pushq and popq; 9 for jXX and call; and 10 for irmovq, rmmovq and mrmovq.
- R4: For 2- and 10-byte instructions, `out_ra` is bits 7:4 and `out_rb` is bits 3:0 of the byte at fetch address + 1. For every other case both read 0xF.
- R5: `out_valc` is the little-endian 64-bit value in bytes 2..9 for 10-byte instructions and in bytes 1..8 for 9-byte instructions. It is zero for all other instructions.
- R6: `next_pred` equals `out_valc` when the opcode is jXX or call, and `out_valp` otherwise.
- R7: `fetch_pc` is `mem_vala` when `mem_icode` is jXX and `mem_cnd` is 0. Otherwise it is `wb_valm` when `wb_icode` is ret. Otherwise it is `pred_pc_in`.
- R8: `flag_bad_instr` is 1 exactly when the address is in range and the opcode is above 0xB.
- R9: When `fetch_pc` is 2048 or more, `flag_bad_addr` is 1. The outputs then describe a one-byte nop: icode 1, ifun 0, both specifiers 0xF, constant 0, `out_valp` = fetch address + 1.
- R10: When the window runs past the end of the store while the fetch address is still in range, the missing bytes read as 0x00 and `flag_bad_addr` stays 0.
- R11: `flag_halt` is 1 exactly when the address is in range and the opcode is 0. At most one of the three flags is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the store load port |
| rst_n | input | 1 | Active-low reset; clears the store and blocks loads |
| load_we | input | 1 | Store write enable |
| load_addr | input | 11 | Store byte address to write |
| load_data | input | 8 | Byte to write |
| pred_pc_in | input | 64 | Prediction held in the stage register |
| mem_icode | input | 4 | Opcode of the instruction in the memory stage |
| mem_cnd | input | 1 | Branch condition of that instruction |
| mem_vala | input | 64 | Fall-through address carried by that instruction |
| wb_icode | input | 4 | Opcode of the instruction in writeback |
| wb_valm | input | 64 | Return address loaded by that instruction |
| fetch_pc | output | 64 | Address actually fetched |
| out_icode | output | 4 | Opcode |
| out_ifun | output | 4 | Function code |
| out_ra | output | 4 | First register specifier |
| out_rb | output | 4 | Second register specifier |
| out_valc | output | 64 | Constant |
| out_valp | output | 64 | Fall-through address |
| next_pred | output | 64 | Predicted next fetch address |
| flag_bad_instr | output | 1 | Illegal opcode |
| flag_bad_addr | output | 1 | Fetch address out of range |
| flag_halt | output | 1 | Halt fetched |

## Verification
On every cycle, the assertions check the following:
- the selection priority between the two corrections and the prediction;
- that the prediction tracks the constant for jumps and calls;
- that the fall-through step is always a legal length;
- that one-byte instructions carry no specifiers;
- the nop substitution for out-of-range addresses;
- that at most one flag is high.

Only the bench scenarios, compared against a byte model of the store, can show the rest:
- that the fields come from the right bytes in the right order;
- that the zero bytes past the end of the store do not raise an address error;
- that loads made during reset are dropped.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

   typedef enum logic [3:0] {
      OP_HALT  = 4'h0,
      OP_NOP   = 4'h1,
      OP_CMOV  = 4'h2,
      OP_IRMOV = 4'h3,
      OP_RMMOV = 4'h4,
      OP_MRMOV = 4'h5,
      OP_ALU   = 4'h6,
      OP_JUMP  = 4'h7,
      OP_CALL  = 4'h8,
      OP_RET   = 4'h9,
      OP_PUSH  = 4'hA,
      OP_POP   = 4'hB
   } opcode_e;

   localparam logic [3:0] REG_NONE = 4'hF;

   // encoding shape of one opcode
   typedef struct packed {
      logic       legal;
      logic       has_regs;
      logic       has_const;
      logic [3:0] len;
   } shape_t;

   function automatic shape_t shape_of(input logic [3:0] code);
      shape_t s;
      s = '{legal: 1'b1, has_regs: 1'b0, has_const: 1'b0, len: 4'd1};
      case (code)
         OP_HALT, OP_NOP, OP_RET: s.len = 4'd1;
         OP_CMOV, OP_ALU, OP_PUSH, OP_POP: begin
            s.has_regs = 1'b1;
            s.len      = 4'd2;
         end
         OP_JUMP, OP_CALL: begin
            s.has_const = 1'b1;
            s.len       = 4'd9;
         end
         OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
            s.has_regs  = 1'b1;
            s.has_const = 1'b1;
            s.len       = 4'd10;
         end
         default: s.legal = 1'b0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/fetch_imem.sv
module fetch_imem #(
   parameter int BYTES = 2048,
   parameter int WIN   = 10,
   parameter int PCW   = 64,
   parameter int AW    = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [7:0]        wdata,
   input  logic [PCW-1:0]    pc,
   output logic [WIN*8-1:0]  window,
   output logic              pc_bad
);
   localparam logic [PCW-1:0] LIMIT = PCW'(BYTES);

   logic [7:0] store [BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < BYTES; i++) store[i] <= 8'h00;
      end else if (we) begin
         store[waddr] <= wdata;
      end
   end

   assign pc_bad = (pc >= LIMIT);

   // one read lane per window byte; lanes past the end read zero
   for (genvar g = 0; g < WIN; g++) begin : g_lane
      logic [PCW-1:0] addr;
      assign addr = pc + PCW'(g);
      assign window[g*8 +: 8] = (addr < LIMIT) ? store[addr[AW-1:0]] : 8'h00;
   end

endmodule

// File: rtl/fetch_split.sv
module fetch_split
   import fetch_pkg::*;
#(
   parameter int PCW = 64,
   parameter int WIN = PCW/8 + 2
) (
   input  logic [PCW-1:0]   pc,
   input  logic [WIN*8-1:0] window,
   input  logic             pc_bad,
   output logic [3:0]       icode,
   output logic [3:0]       ifun,
   output logic [3:0]       ra,
   output logic [3:0]       rb,
   output logic [PCW-1:0]   valc,
   output logic [PCW-1:0]   valp,
   output logic             bad_instr,
   output logic             halt
);
   shape_t     sh;
   logic [3:0] len;

   always_comb begin
      sh = shape_of(window[7:4]);
      if (pc_bad) begin
         icode     = OP_NOP;
         ifun      = 4'h0;
         ra        = REG_NONE;
         rb        = REG_NONE;
         valc      = '0;
         len       = 4'd1;
         bad_instr = 1'b0;
         halt      = 1'b0;
      end else begin
         icode     = window[7:4];
         ifun      = window[3:0];
         ra        = sh.has_regs ? window[15:12] : REG_NONE;
         rb        = sh.has_regs ? window[11:8]  : REG_NONE;
         if (!sh.has_const)    valc = '0;
         else if (sh.has_regs) valc = window[WIN*8-1:16];
         else                  valc = window[PCW+7:8];
         len       = sh.len;
         bad_instr = !sh.legal;
         halt      = (window[7:4] == OP_HALT);
      end
      valp = pc + PCW'(len);
   end

endmodule

// File: rtl/fetch_predict.sv
module fetch_predict
   import fetch_pkg::*;
#(
   parameter int PCW = 64
) (
   input  logic [3:0]     icode,
   input  logic [PCW-1:0] valc,
   input  logic [PCW-1:0] valp,
   output logic [PCW-1:0] pred
);
   always_comb begin
      if (icode == OP_JUMP || icode == OP_CALL) pred = valc;
      else                                      pred = valp;
   end
endmodule

// File: rtl/fetch_pc_select.sv
module fetch_pc_select
   import fetch_pkg::*;
#(
   parameter int PCW = 64
) (
   input  logic [PCW-1:0] pred_pc,
   input  logic [3:0]     m_icode,
   input  logic           m_cnd,
   input  logic [PCW-1:0] m_vala,
   input  logic [3:0]     w_icode,
   input  logic [PCW-1:0] w_valm,
   output logic [PCW-1:0] pc
);
   logic mispredict, returning;

   assign mispredict = (m_icode == OP_JUMP) && !m_cnd;
   assign returning  = (w_icode == OP_RET);

   always_comb begin
      if (mispredict)     pc = m_vala;
      else if (returning) pc = w_valm;
      else                pc = pred_pc;
   end
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
   import fetch_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int IMEM_BYTES = 2048,
   parameter int ADDR_W     = $clog2(IMEM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_we,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [7:0]        load_data,
   input  logic [XLEN-1:0]   pred_pc_in,
   input  logic [3:0]        mem_icode,
   input  logic              mem_cnd,
   input  logic [XLEN-1:0]   mem_vala,
   input  logic [3:0]        wb_icode,
   input  logic [XLEN-1:0]   wb_valm,
   output logic [XLEN-1:0]   fetch_pc,
   output logic [3:0]        out_icode,
   output logic [3:0]        out_ifun,
   output logic [3:0]        out_ra,
   output logic [3:0]        out_rb,
   output logic [XLEN-1:0]   out_valc,
   output logic [XLEN-1:0]   out_valp,
   output logic [XLEN-1:0]   next_pred,
   output logic              flag_bad_instr,
   output logic              flag_bad_addr,
   output logic              flag_halt
);
   localparam int WIN_BYTES = XLEN/8 + 2;

   if (XLEN % 8 != 0 || XLEN < 16) begin : g_bad_xlen
      $error("fetch_unit: XLEN must be a multiple of 8 and at least 16");
   end
   if (IMEM_BYTES != (1 << ADDR_W) || IMEM_BYTES < 16) begin : g_bad_depth
      $error("fetch_unit: IMEM_BYTES must be a power of two of at least 16");
   end

   logic [WIN_BYTES*8-1:0] window;
   logic                   pc_bad;

   fetch_pc_select #(.PCW(XLEN)) u_sel (
      .pred_pc (pred_pc_in),
      .m_icode (mem_icode),
      .m_cnd   (mem_cnd),
      .m_vala  (mem_vala),
      .w_icode (wb_icode),
      .w_valm  (wb_valm),
      .pc      (fetch_pc)
   );

   fetch_imem #(.BYTES(IMEM_BYTES), .WIN(WIN_BYTES), .PCW(XLEN), .AW(ADDR_W)) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (load_we),
      .waddr  (load_addr),
      .wdata  (load_data),
      .pc     (fetch_pc),
      .window (window),
      .pc_bad (pc_bad)
   );

   fetch_split #(.PCW(XLEN), .WIN(WIN_BYTES)) u_split (
      .pc        (fetch_pc),
      .window    (window),
      .pc_bad    (pc_bad),
      .icode     (out_icode),
      .ifun      (out_ifun),
      .ra        (out_ra),
      .rb        (out_rb),
      .valc      (out_valc),
      .valp      (out_valp),
      .bad_instr (flag_bad_instr),
      .halt      (flag_halt)
   );

   fetch_predict #(.PCW(XLEN)) u_pred (
      .icode (out_icode),
      .valc  (out_valc),
      .valp  (out_valp),
      .pred  (next_pred)
   );

   assign flag_bad_addr = pc_bad;

   // ---------------- assertions ----------------
   logic [XLEN-1:0] step;
   assign step = out_valp - fetch_pc;

   p_step_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_bad_addr && !flag_bad_instr) |->
      (step == XLEN'(1) || step == XLEN'(2) || step == XLEN'(9) || step == XLEN'(10)));

   p_short_noregs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step == XLEN'(1)) |-> (out_ra == REG_NONE && out_rb == REG_NONE));

   p_pred_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_icode == OP_JUMP || out_icode == OP_CALL) |-> (next_pred == out_valc));

   p_pred_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_icode == OP_JUMP || out_icode == OP_CALL) |-> (next_pred == out_valp));

   p_misp_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_icode == OP_JUMP && !mem_cnd) |-> (fetch_pc == mem_vala));

   p_ret_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!(mem_icode == OP_JUMP && !mem_cnd) && wb_icode == OP_RET) |-> (fetch_pc == wb_valm));

   p_addr_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_bad_addr |-> (out_icode == OP_NOP && out_valc == '0 && step == XLEN'(1)));

   p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flag_bad_instr, flag_bad_addr, flag_halt}));

endmodule

// File: tb/sim_fetch_unit.sv
`timescale 1ns/1ps
module sim_fetch_unit;
   localparam int DEPTH = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_we = 1'b0;
   logic [10:0] load_addr = '0;
   logic [7:0]  load_data = '0;
   logic [63:0] pred_pc_in = '0;
   logic [3:0]  mem_icode = 4'h1;
   logic        mem_cnd = 1'b1;
   logic [63:0] mem_vala = '0;
   logic [3:0]  wb_icode = 4'h1;
   logic [63:0] wb_valm = '0;
   logic [63:0] fetch_pc, out_valc, out_valp, next_pred;
   logic [3:0]  out_icode, out_ifun, out_ra, out_rb;
   logic        flag_bad_instr, flag_bad_addr, flag_halt;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [7:0] mdl [DEPTH];

   always #10 clk = ~clk;

   fetch_unit u0 (
      .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
      .load_data(load_data), .pred_pc_in(pred_pc_in), .mem_icode(mem_icode),
      .mem_cnd(mem_cnd), .mem_vala(mem_vala), .wb_icode(wb_icode),
      .wb_valm(wb_valm), .fetch_pc(fetch_pc), .out_icode(out_icode),
      .out_ifun(out_ifun), .out_ra(out_ra), .out_rb(out_rb),
      .out_valc(out_valc), .out_valp(out_valp), .next_pred(next_pred),
      .flag_bad_instr(flag_bad_instr), .flag_bad_addr(flag_bad_addr),
      .flag_halt(flag_halt)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic load_byte(input int a, input logic [7:0] d);
      @(negedge clk);
      load_we = 1'b1; load_addr = 11'(a); load_data = d;
      @(negedge clk);
      load_we = 1'b0;
      if (rst_n) mdl[a] = d;
   endtask

   // drive one fetch request and compare every output with the byte model
   task automatic run_case(input logic [63:0] pp, input logic [3:0] mi, input logic mc,
                           input logic [63:0] va, input logic [3:0] wi, input logic [63:0] wv);
      logic [63:0] spc, evalc, evalp, epred, a;
      logic [7:0]  b [10];
      logic [3:0]  ei, ef, era, erb;
      logic        ebi, eba, eh;
      int          n;
      @(negedge clk);
      pred_pc_in = pp; mem_icode = mi; mem_cnd = mc; mem_vala = va;
      wb_icode = wi; wb_valm = wv;
      #2;
      if (mi == 4'h7 && !mc) spc = va;
      else if (wi == 4'h9)   spc = wv;
      else                   spc = pp;
      for (int i = 0; i < 10; i++) begin
         a = spc + 64'(i);
         b[i] = (a < 64'(DEPTH)) ? mdl[a[10:0]] : 8'h00;
      end
      eba = (spc >= 64'(DEPTH));
      ei = b[0][7:4]; ef = b[0][3:0]; era = 4'hF; erb = 4'hF;
      evalc = '0; n = 1; ebi = 1'b0; eh = 1'b0;
      if (eba) begin
         ei = 4'h1; ef = 4'h0;
      end else begin
         case (ei)
            4'h0, 4'h1, 4'h9: n = 1;
            4'h2, 4'h6, 4'hA, 4'hB: begin
               n = 2; era = b[1][7:4]; erb = b[1][3:0];
            end
            4'h7, 4'h8: begin
               n = 9; evalc = {b[8], b[7], b[6], b[5], b[4], b[3], b[2], b[1]};
            end
            4'h3, 4'h4, 4'h5: begin
               n = 10; era = b[1][7:4]; erb = b[1][3:0];
               evalc = {b[9], b[8], b[7], b[6], b[5], b[4], b[3], b[2]};
            end
            default: ebi = 1'b1;
         endcase
         eh = (ei == 4'h0);
      end
      evalp = spc + 64'(n);
      epred = (ei == 4'h7 || ei == 4'h8) ? evalc : evalp;
      chk("R7", "fetch_pc", fetch_pc, spc);
      chk("R2", "icode", 64'(out_icode), 64'(ei));
      chk("R2", "ifun", 64'(out_ifun), 64'(ef));
      chk("R4", "ra", 64'(out_ra), 64'(era));
      chk("R4", "rb", 64'(out_rb), 64'(erb));
      chk("R5", "valc", out_valc, evalc);
      chk("R3", "valp", out_valp, evalp);
      chk("R6", "pred", next_pred, epred);
      chk("R8", "bad_instr", 64'(flag_bad_instr), 64'(ebi));
      chk("R9", "bad_addr", 64'(flag_bad_addr), 64'(eba));
      chk("R11", "halt", 64'(flag_halt), 64'(eh));
   endtask

   initial begin
      #(20.0 * 200000);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
      repeat (2) @(negedge clk);
      // R1: reset clears the store; a load during reset is dropped
      load_byte(5, 8'hAB);
      #2;
      chk("R1", "reset icode", 64'(out_icode), 64'h0);
      chk("R1", "reset halt", 64'(flag_halt), 64'h1);
      chk("R1", "reset valp", out_valp, 64'h1);
      @(negedge clk); rst_n = 1'b1;
      run_case(64'd5, 4'h1, 1'b1, 64'd0, 4'h1, 64'd0);   // R1 byte 5 still zero

      // random fill: opcodes 0..0xD, so a few are illegal
      for (int i = 0; i < DEPTH; i++)
         load_byte(i, {4'($urandom % 14), 4'($urandom)});

      // directed: 10-byte immediate move at 0x100 (R5 little-endian)
      load_byte(32'h100, 8'h30); load_byte(32'h101, 8'hF3);
      for (int i = 0; i < 8; i++) load_byte(32'h102 + i, 8'(64'h0123456789ABCDEF >> (8*i)));
      run_case(64'h100, 4'h0, 1'b0, 64'd0, 4'h0, 64'd0);
      chk("R5", "directed irmov valc", out_valc, 64'h0123456789ABCDEF);
      // directed: jump at 0x200, prediction is its target (R6)
      load_byte(32'h200, 8'h70);
      for (int i = 0; i < 8; i++) load_byte(32'h201 + i, (i == 0) ? 8'h40 : 8'h00);
      run_case(64'h200, 4'h1, 1'b1, 64'd0, 4'h1, 64'd0);
      chk("R6", "directed jump pred", next_pred, 64'h40);
      // R10: 10-byte move at the last two bytes, tail reads zero
      load_byte(2046, 8'h30); load_byte(2047, 8'hF1);
      run_case(64'd2046, 4'h1, 1'b1, 64'd0, 4'h1, 64'd0);
      chk("R10", "tail valc", out_valc, 64'h0);
      chk("R10", "tail no addr error", 64'(flag_bad_addr), 64'h0);
      // R9: first address past the end, and a huge one
      run_case(64'd2048, 4'h1, 1'b1, 64'd0, 4'h1, 64'd0);
      run_case(64'hFFFF_FFFF_FFFF_FFFF, 4'h1, 1'b1, 64'd0, 4'h1, 64'd0);
      // R7: mispredict wins over ret; ret wins over prediction; taken jump ignored
      run_case(64'd10, 4'h7, 1'b0, 64'd20, 4'h9, 64'd30);
      chk("R7", "mispredict first", fetch_pc, 64'd20);
      run_case(64'd10, 4'h7, 1'b1, 64'd20, 4'h9, 64'd30);
      chk("R7", "ret second", fetch_pc, 64'd30);
      run_case(64'd10, 4'h7, 1'b1, 64'd20, 4'h2, 64'd30);
      chk("R7", "prediction last", fetch_pc, 64'd10);

      // constrained random
      for (int k = 0; k < 3000; k++) begin
         logic [63:0] pp, va, wv;
         pp = ($urandom % 16 == 0) ? {32'($urandom), 32'($urandom)} : 64'($urandom % 2100);
         va = 64'($urandom % 2100);
         wv = 64'($urandom % 2100);
         run_case(pp, 4'($urandom), 1'($urandom), va, 4'($urandom), wv);
      end

      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule